// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block keeps a processor's clock configuration: a PLL multiplier code, a core-clock divider code and a peripheral-clock divider code. Software changes them through a small register bus. A change to the divider codes alone takes effect on the next clock edge. A change to the multiplier has to wait for the PLL to settle. In that case the block withdraws the core and peripheral clock enables and runs an 8-bit settling counter from a start value that software loaded. When the counter overflows, the block drives out the new settings and returns the enables.

The settling counter advances on ticks from a prescaler. A 3-bit select in a timer control register chooses the tick interval. An enable bit in the same register can hold the counter still. A status register shows whether a stall is in progress. It also holds a sticky overflow flag and a sticky divider-error flag. The error flag is raised when a write carries a divider code outside the permitted range.

Top module: `clkseq_top`

## Requirements
- R1: After reset, mult_sel is 0 (ratio 1), core_div_sel is 0, periph_div_sel is 2, both clock enables are 1 and stall_o is 0. The counter register, the timer control register and the status register all read 0.
- R2: Address 0 is the frequency register, with the multiplier in bits [2:0], the core divider in bits [6:4] and the peripheral divider in bits [10:8]. Writing it while idle with valid divider codes and a multiplier different from the current one sets stall_o on the next edge and clears both clock enables. The ratio outputs keep their old values.
- R3: Address 2 is the timer control register: bit [0] is the enable and bits [3:1] are the select. During a stall with the enable set, the counter at address 1 (bits [7:0]) rises by one every P clocks. P is 1, 4, 16, 32, 64, 256, 1024 or 4096 for select codes 0 to 7. A stall started from count C therefore lasts exactly (256-C)*P cycles.
- R4: On overflow the counter wraps to 0 and stops. The written multiplier and divider codes appear on the ratio outputs, stall_o falls and both clock enables return to 1.
- R5: A valid write to address 0 that keeps the current multiplier updates the divider outputs on the next edge. It never stalls and leaves the counter value unchanged.
- R6: With the timer enable at 0, a stall does not advance the counter and the stall does not end.
- R7: During a stall, writes to the counter, the timer control register and the frequency register are ignored.
- R8: Address 3 is the status register: bit [0] shows the stall, bit [1] the overflow flag and bit [2] the divider-error flag. Any write to address 3 clears both flags. If overflow occurs in the same cycle as that write, the overflow flag is still set.
- R9: A write to address 0 whose core or peripheral divider code is above 4 is rejected. All three fields keep their values, no stall starts and the error flag is set.
- R10: Reading address 0 returns the currently applied codes in the R2 layout. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Read data (combinational from bus_addr) |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| stall_o | output | 1 | High while a multiplier change is settling |
| mult_sel | output | 3 | Applied PLL multiplier code |
| core_div_sel | output | 3 | Applied core divider code |
| periph_div_sel | output | 3 | Applied peripheral divider code |

## Verification
Two functions can fall in the same cycle: the overflow that ends a stall, and a software write that clears the status flags. The bench computes the exact overflow edge as (256-C)*P cycles after the frequency write. It places a status write on that edge and expects the overflow flag to read 1 afterwards. A second write then clears it. Stall length is swept over every prescale select and compared with the arithmetic value. Each of the 64 divider-code pairs is also tried and judged against the permitted range.

// File: rtl/clkseq_pkg.sv
// Package: shared field widths, register addresses and the clock
// configuration record used by the ratio sequencer.
package clkseq_pkg;
    localparam int FIELD_W = 3;
    localparam int DATA_W  = 11;

    typedef enum logic [1:0] {
        REG_FREQ  = 2'd0,
        REG_COUNT = 2'd1,
        REG_TCTL  = 2'd2,
        REG_STAT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FIELD_W-1:0] per;
        logic [FIELD_W-1:0] core;
        logic [FIELD_W-1:0] mult;
    } clk_cfg_t;

    // Log2 of the tick interval for each prescale select code.
    function automatic logic [3:0] presc_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    presc_shift = 4'd0;
            3'd1:    presc_shift = 4'd2;
            3'd2:    presc_shift = 4'd4;
            3'd3:    presc_shift = 4'd5;
            3'd4:    presc_shift = 4'd6;
            3'd5:    presc_shift = 4'd8;
            3'd6:    presc_shift = 4'd10;
            default: presc_shift = 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/clkseq_prescaler.sv
// Tick generator: while active, raises tick once every 2^shift(sel) clocks,
// the first tick coming at the end of the first full interval.
// Assumes sel does not change while active; restarts from zero when idle.
module clkseq_prescaler
    import clkseq_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;

    // Terminal count for the selected interval.
    always_comb lim = PRE_W'((1 << presc_shift(sel)) - 1);

    assign tick = active && (pcnt == lim);

    // Interval counter, cleared when idle or on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt <= '0;
        else if (!active)    pcnt <= '0;
        else if (tick)       pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active && sel != 3'd0) |=> !tick);
endmodule

// File: rtl/clkseq_settle_timer.sv
// Settling counter: 8-bit up-counter and its control (enable, prescale
// select). Counts prescaler ticks only while run is high; flags overflow.
// Assumes run stays high until ovf_o; software writes are taken only idle.
module clkseq_settle_timer
    import clkseq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_wr,
    input  logic             ctl_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ten_o,
    output logic [2:0]       tsel_o,
    output logic             ovf_o
);
    logic tick;

    clkseq_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (run && ten_o),
        .sel    (tsel_o),
        .tick   (tick)
    );

    assign ovf_o = tick && (&cnt_o);

    // Counter: software load when idle, tick increment while running.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_o <= '0;
        else if (!run && cnt_wr)  cnt_o <= wdata;
        else if (tick)            cnt_o <= cnt_o + 1'b1;
    end

    // Control register: enable and prescale select, writable when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ten_o  <= 1'b0;
            tsel_o <= 3'd0;
        end else if (!run && ctl_wr) begin
            ten_o  <= wdata[0];
            tsel_o <= wdata[3:1];
        end
    end

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ten_o) |=> $stable(cnt_o));
    // R7
    ctl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl_wr) |=> ($stable(ten_o) && $stable(tsel_o)));
    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == '0));
endmodule

// File: rtl/clkseq_freq_ctrl.sv
// Frequency control: holds applied and pending clock codes, decides between
// an immediate divider update and a stalled multiplier change, rejects
// out-of-range divider codes. Assumes ovf arrives only while stalled.
module clkseq_freq_ctrl
    import clkseq_pkg::*;
#(
    parameter int DIV_MAX = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  clk_cfg_t wcfg,
    input  logic     ovf,
    output clk_cfg_t cfg_o,
    output logic     stall_o,
    output logic     err_o
);
    localparam logic [FIELD_W-1:0] DIV_LIM = FIELD_W'(DIV_MAX);
    localparam clk_cfg_t CFG_RST = '{per: 3'd2, core: 3'd0, mult: 3'd0};

    clk_cfg_t pend;
    logic     valid;
    logic     mult_chg;

    assign valid    = (wcfg.core <= DIV_LIM) && (wcfg.per <= DIV_LIM);
    assign mult_chg = (wcfg.mult != cfg_o.mult);
    assign err_o    = wr && !stall_o && !valid;

    // Sequencing: apply at overflow, stall on multiplier change, else apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o   <= CFG_RST;
            pend    <= CFG_RST;
            stall_o <= 1'b0;
        end else if (stall_o) begin
            if (ovf) begin
                cfg_o   <= pend;
                stall_o <= 1'b0;
            end
        end else if (wr && valid) begin
            if (mult_chg) begin
                pend    <= wcfg;
                stall_o <= 1'b1;
            end else begin
                cfg_o   <= wcfg;
            end
        end
    end

    // R2
    mult_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && wr && valid && mult_chg) |=> (stall_o && $stable(cfg_o)));
    // R5
    div_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && wr && valid && !mult_chg) |=> (!stall_o && cfg_o == $past(wcfg)));
    // R9
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !valid) |=> $stable(cfg_o));
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !ovf) |=> (stall_o && $stable(cfg_o)));
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && ovf) |=> !stall_o);
endmodule

// File: rtl/clkseq_top.sv
// Top: register decode and readback, sticky status flags, clock-enable
// outputs. Assumes bus_rdata is sampled combinationally from bus_addr.
module clkseq_top
    import clkseq_pkg::*;
#(
    parameter int DIV_MAX = 4,
    parameter int CNT_W   = 8,
    parameter int PRE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic              stall_o,
    output logic [2:0]        mult_sel,
    output logic [2:0]        core_div_sel,
    output logic [2:0]        periph_div_sel
);
    clk_cfg_t         wcfg, cfg;
    logic             wr_freq, wr_cnt, wr_tctl, wr_stat;
    logic             ovf, err_pulse, ovf_flag, err_flag;
    logic [CNT_W-1:0] cnt;
    logic             ten;
    logic [2:0]       tsel;

    assign wr_freq = bus_wr && (bus_addr == REG_FREQ);
    assign wr_cnt  = bus_wr && (bus_addr == REG_COUNT);
    assign wr_tctl = bus_wr && (bus_addr == REG_TCTL);
    assign wr_stat = bus_wr && (bus_addr == REG_STAT);

    assign wcfg = '{per: bus_wdata[10:8], core: bus_wdata[6:4], mult: bus_wdata[2:0]};

    clkseq_freq_ctrl #(.DIV_MAX(DIV_MAX)) u_freq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_freq),
        .wcfg    (wcfg),
        .ovf     (ovf),
        .cfg_o   (cfg),
        .stall_o (stall_o),
        .err_o   (err_pulse)
    );

    clkseq_settle_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (stall_o),
        .cnt_wr (wr_cnt),
        .ctl_wr (wr_tctl),
        .wdata  (bus_wdata[CNT_W-1:0]),
        .cnt_o  (cnt),
        .ten_o  (ten),
        .tsel_o (tsel),
        .ovf_o  (ovf)
    );

    assign core_clk_en    = !stall_o;
    assign periph_clk_en  = !stall_o;
    assign mult_sel       = cfg.mult;
    assign core_div_sel   = cfg.core;
    assign periph_div_sel = cfg.per;

    // Sticky flags: event sets, status write clears, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (ovf)            ovf_flag <= 1'b1;
            else if (wr_stat)   ovf_flag <= 1'b0;
            if (err_pulse)      err_flag <= 1'b1;
            else if (wr_stat)   err_flag <= 1'b0;
        end
    end

    // Read multiplexer over the four registers.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_FREQ:  bus_rdata = {cfg.per, 1'b0, cfg.core, 1'b0, cfg.mult};
            REG_COUNT: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
            REG_TCTL:  bus_rdata = {{(DATA_W-4){1'b0}}, tsel, ten};
            default:   bus_rdata = {{(DATA_W-3){1'b0}}, err_flag, ovf_flag, stall_o};
        endcase
    end

    // R8
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf_flag);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !ovf) |=> !ovf_flag);
    // R9
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (err_flag && !stall_o));
endmodule

// File: tb/sim_clkseq_top.sv
`timescale 1ns/1ps
module sim_clkseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [10:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic        core_clk_en, periph_clk_en, stall_o;
    logic [2:0]  mult_sel, core_div_sel, periph_div_sel;

    int checks = 0;
    int errors = 0;
    logic [2:0] em = 3'd0, ec = 3'd0, ep = 3'd2;
    int sh [8] = '{0, 2, 4, 5, 6, 8, 10, 12};

    always #2 clk = ~clk;

    clkseq_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .stall_o(stall_o),
        .mult_sel(mult_sel), .core_div_sel(core_div_sel), .periph_div_sel(periph_div_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] fw(input logic [2:0] m, input logic [2:0] c, input logic [2:0] p);
        return {p, 1'b0, c, 1'b0, m};
    endfunction

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [10:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a; #1; v = int'(bus_rdata);
    endtask

    task automatic chk_cfg(input string req);
        int v;
        chk(req, int'(mult_sel), int'(em));
        chk(req, int'(core_div_sel), int'(ec));
        chk(req, int'(periph_div_sel), int'(ep));
        rd(2'd0, v);
        chk("R10", v, int'(fw(em, ec, ep)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        em = 3'd0; ec = 3'd0; ep = 3'd2;
    endtask

    task automatic reset_checks();
        int v;
        chk_cfg("R1");
        chk("R1", int'(core_clk_en), 1);
        chk("R1", int'(periph_clk_en), 1);
        chk("R1", int'(stall_o), 0);
        rd(2'd1, v); chk("R1", v, 0);
        rd(2'd2, v); chk("R1", v, 0);
        rd(2'd3, v); chk("R1", v, 0);
    endtask

    // Stall run with given select and start count; exact length is measured.
    task automatic settle_run(input logic [2:0] sel, input logic [7:0] start);
        int n, v, p, expn;
        logic [2:0] nm, nc, np;
        p = 1 << sh[sel];
        expn = (256 - int'(start)) * p;
        nm = em + 3'd1; nc = 3'(int'(sel) % 5); np = 3'((int'(sel) + 2) % 5);
        wr(2'd2, {7'd0, sel, 1'b1});
        wr(2'd1, {3'd0, start});
        wr(2'd0, fw(nm, nc, np));
        n = 0;
        while (stall_o && n < 20000) begin
            n++;
            if (n == 1) begin
                chk("R2", int'(core_clk_en), 0);
                chk("R2", int'(periph_clk_en), 0);
                chk("R2", int'(mult_sel), int'(em));
                bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 11'd0;
            end else if (n == 2) begin
                bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = fw(nm + 3'd3, 3'd4, 3'd4);
            end else begin
                bus_wr = 1'b0;
                if (n == expn / 2 + 1) begin
                    rd(2'd1, v);
                    chk("R3", v, int'(start) + (expn / 2) / p);
                end
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        chk("R3", n, expn);
        em = nm; ec = nc; ep = np;
        chk_cfg("R4");
        chk("R4", int'(core_clk_en), 1);
        rd(2'd1, v); chk("R4", v, 0);
        rd(2'd3, v); chk("R4", v, 2);
        rd(2'd2, v); chk("R7", v, int'({sel, 1'b1}));
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R4", v, 0);
        wr(2'd3, 11'd0);
        rd(2'd3, v); chk("R8", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        do_reset();
        reset_checks();

        // R3 R4 R2 R7: every prescale select, then a full 256-tick run
        for (int s = 0; s < 8; s++) begin
            settle_run(3'(s), (s < 5) ? 8'd240 : 8'd254);
        end
        settle_run(3'd0, 8'd0);

        // R8: status write on the overflow edge itself
        wr(2'd2, 11'b0001);
        wr(2'd1, 11'd250);
        wr(2'd0, fw(em + 3'd1, ec, ep));
        repeat (5) @(negedge clk);
        chk("R8", int'(stall_o), 1);
        wr(2'd3, 11'd0);
        em = em + 3'd1;
        rd(2'd3, v); chk("R8", v, 2);
        wr(2'd3, 11'd0);
        rd(2'd3, v); chk("R8", v, 0);

        // R5 R9: sweep all divider code pairs with the multiplier unchanged
        wr(2'd1, 11'd77);
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 8; p++) begin
                bit ok;
                ok = (c <= 4) && (p <= 4);
                wr(2'd0, fw(em, 3'(c), 3'(p)));
                chk(ok ? "R5" : "R9", int'(stall_o), 0);
                if (ok) begin ec = 3'(c); ep = 3'(p); end
                chk_cfg(ok ? "R5" : "R9");
                rd(2'd3, v); chk("R9", v, ok ? 0 : 4);
                wr(2'd3, 11'd0);
            end
        end
        rd(2'd1, v); chk("R5", v, 77);

        // R9: invalid code with a multiplier change still starts nothing
        wr(2'd0, fw(em + 3'd2, 3'd6, 3'd1));
        chk("R9", int'(stall_o), 0);
        chk_cfg("R9");
        wr(2'd3, 11'd0);

        // R6: timer disabled keeps the stall and the count frozen
        wr(2'd2, 11'b0000);
        wr(2'd1, 11'd250);
        wr(2'd0, fw(em + 3'd1, ec, ep));
        repeat (40) @(negedge clk);
        chk("R6", int'(stall_o), 1);
        rd(2'd1, v); chk("R6", v, 250);
        chk("R6", int'(mult_sel), int'(em));

        // R1: reset returns everything to its initial state
        do_reset();
        reset_checks();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule